// File: doc/BRIEF.md
# Serial EEPROM Slave Command Engine

This block acts as a small serial-peripheral EEPROM slave with 512 bytes of storage. Its storage is an array of on-chip registers. A master drives an active-low select, a serial clock and a serial data line. The engine decodes four instructions:

- read
- byte write
- write enable
- status read

Replies are shifted out on a serial output line. The block also drives an output-enable flag, which stands in for a tri-state driver. The array address is nine bits wide. The low eight bits travel in the byte after the instruction, and the top bit travels inside the instruction byte itself.

The three serial inputs are taken into the system clock domain through a short synchronizer. Every protocol decision is made on edges seen in that domain:

- Data is sampled on rising serial-clock edges.
- Data is driven on falling serial-clock edges (mode 0).

A write is held back until select returns high. It goes through only if all of these hold:

- the write latch was armed in an earlier select period,
- exactly 24 bits were clocked,
- the target lies outside the block-protect range.

After such a write, the engine reports busy for a fixed number of system clocks.

Top module: `spi_eeprom_slave`

## Requirements
- R1: After reset the output enable is low, the status byte reads 0x04 with the default protect code 01, and every array byte reads 0xFF.
- R2: The write latch (status bit 1) is set only when select rises after exactly the 8 bits of instruction 0000_0110. Without it, a write leaves the array unchanged. A write instruction sent in the same select period as the enable instruction programs nothing and leaves the latch clear.
- R3: A write is instruction 0000_A010, where A is address bit 8, then the low address byte, then 8 data bits MSB first. The byte is stored when select rises.
- R4: A write is stored only if select rises after exactly 24 clocked bits. With 23 or 25 bits, the write is dropped and the write latch stays set.
- R5: Status bits 3:2 hold the protect code. Code 01 protects 0x180 to 0x1FF, code 10 protects the upper half, code 11 protects everything, and code 00 protects nothing. A write into the protected range is dropped and the latch stays set. Address 0x17F is writable under code 01.
- R6: A read is instruction 0000_A011, then the low address byte. Data bytes follow MSB first, each bit driven on a falling clock edge. Further bytes come from incrementing addresses, and 0x1FF wraps to 0x000.
- R7: Instruction 0000_0101 returns the status byte {0000, protect[1:0], latch, busy} MSB first, repeated for as long as clocks continue. The output enable stays low while instruction or address bits are clocked, and whenever select is high.
- R8: A stored write sets busy (status bit 0) for BUSY_CYCLES system clocks. While busy, only the status instruction is honoured, and a read leaves the output disabled.
- R9: A stored write clears the write latch.
- R10: Select rising at any bit count ends the current instruction. The next select period starts with an instruction byte, and a partial enable instruction sets nothing.
- R11: An instruction byte matching none of the codes above is ignored. The output stays disabled and the status is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low select from the master |
| sck | input | 1 | Serial clock from the master, idle low |
| mosi | input | 1 | Serial data into the slave |
| miso | output | 1 | Serial data out of the slave |
| miso_oe | output | 1 | High while the slave drives miso |

## Verification
The inputs pass through a two-stage synchronizer plus one decision register. As a result, `miso` and `miso_oe` change about three system clocks after a falling serial-clock edge. The bench holds each serial-clock phase for eight system clocks and samples the reply just before the next rising edge, well after the output has settled.

A write is stored a few clocks after select rises, and busy appears one clock after that. The bench therefore waits four half-periods after every deselect, and runs the status instruction inside the busy window. It waits past BUSY_CYCLES before expecting busy to clear.

Read and status bytes are pushed as expected values into a scoreboard queue and compared in arrival order. Output-enable behaviour is checked directly at each sampling point.

// File: rtl/eeprom_pkg.sv
// Shared types and instruction codes for the serial EEPROM slave.
// Assumes a nine-bit byte address with bit 8 carried in instruction bit 3.
package eeprom_pkg;
    localparam int ADDR_W = 9;
    localparam int DATA_W = 8;

    localparam logic [7:0] OPC_MASK  = 8'hF7;   // clears the address-bit-8 slot
    localparam logic [7:0] OPC_READ  = 8'h03;
    localparam logic [7:0] OPC_WRITE = 8'h02;
    localparam logic [7:0] OPC_WREN  = 8'h06;
    localparam logic [7:0] OPC_RDSR  = 8'h05;

    typedef enum logic [2:0] {
        PH_OPC, PH_ADDR, PH_DATA, PH_OUT, PH_SKIP
    } phase_t;

    typedef enum logic [1:0] {
        CMD_READ, CMD_WRITE, CMD_RDSR
    } cmd_t;
endpackage

// File: rtl/spi_in_sync.sv
// Brings select, serial clock and serial data into the system clock domain
// and flags edges. Assumes each serial phase lasts several system clocks and
// STAGES >= 2.
module spi_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    output logic sel,
    output logic sel_end,
    output logic sck_rise,
    output logic sck_fall,
    output logic mosi_s
);
    logic [STAGES:0] cs_p, sck_p, mosi_p;

    // shift the raw inputs through the synchronizer chains
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_p   <= '1;
            sck_p  <= '0;
            mosi_p <= '0;
        end else begin
            cs_p   <= {cs_p[STAGES-1:0], cs_n};
            sck_p  <= {sck_p[STAGES-1:0], sck};
            mosi_p <= {mosi_p[STAGES-1:0], mosi};
        end
    end

    assign sel      = ~cs_p[STAGES-1];
    assign sel_end  = cs_p[STAGES-1] & ~cs_p[STAGES];
    assign sck_rise = sck_p[STAGES-1] & ~sck_p[STAGES];
    assign sck_fall = ~sck_p[STAGES-1] & sck_p[STAGES];
    assign mosi_s   = mosi_p[STAGES-1];
endmodule

// File: rtl/busy_timer.sv
// Counts the modelled internal write time in system clocks.
// Assumes start only arrives while idle.
module busy_timer #(
    parameter int CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] cnt;

    // load on start, then count down to idle
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (start)       cnt <= CW'(CYCLES);
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy); // R8
endmodule

// File: rtl/eeprom_store.sv
// Register array with all-ones reset and a protect decoder picked by a
// parameter. One address serves both the read and the write path.
module eeprom_store #(
    parameter int         AW      = 9,
    parameter int         DW      = 8,
    parameter logic [1:0] PROTECT = 2'd1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          wr_blocked
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] mem [DEPTH];

    // erased state at reset, single-byte update on a write strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

    if (PROTECT == 2'd0) begin : g_open
        assign wr_blocked = 1'b0;
    end else if (PROTECT == 2'd1) begin : g_quarter
        assign wr_blocked = (addr[AW-1:AW-2] == 2'b11);
    end else if (PROTECT == 2'd2) begin : g_half
        assign wr_blocked = addr[AW-1];
    end else begin : g_all
        assign wr_blocked = 1'b1;
    end

    AST_PROTECTED_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> !wr_blocked); // R5
endmodule

// File: rtl/spi_eeprom_slave.sv
// Command engine of a 512-byte serial EEPROM slave, mode 0. Decodes read,
// write, write-enable and status instructions, arms the write latch on
// deselect, and stores a byte only on a deselect right after 24 bits.
// Assumes every serial phase spans at least four system clocks.
module spi_eeprom_slave
    import eeprom_pkg::*;
#(
    parameter int         BUSY_CYCLES = 400,
    parameter logic [1:0] PROTECT     = 2'd1,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    output logic miso,
    output logic miso_oe
);
    localparam int          CNT_W    = 5;
    localparam logic [CNT_W-1:0] OPC_LAST = CNT_W'(7);
    localparam logic [CNT_W-1:0] ADR_LAST = CNT_W'(15);
    localparam logic [CNT_W-1:0] WR_BITS  = CNT_W'(24);
    localparam logic [CNT_W-1:0] CNT_SAT  = '1;

    logic sel, sel_end, sck_rise, sck_fall, mosi_s;
    logic busy, wr_blocked;
    logic [DATA_W-1:0] rdata, new_byte, status, shreg, out_sh, wdata_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  bcnt;
    logic [2:0]        out_bits;
    phase_t ph;
    cmd_t   cmd;
    logic a8, wel_q, wren_pend, load_req, we_q, miso_q, oe_q, commit_ok;

    spi_in_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .sel(sel), .sel_end(sel_end), .sck_rise(sck_rise),
        .sck_fall(sck_fall), .mosi_s(mosi_s)
    );

    eeprom_store #(.AW(ADDR_W), .DW(DATA_W), .PROTECT(PROTECT)) i_store (
        .clk(clk), .rst_n(rst_n), .we(we_q), .addr(addr_q),
        .wdata(wdata_q), .rdata(rdata), .wr_blocked(wr_blocked)
    );

    busy_timer #(.CYCLES(BUSY_CYCLES)) i_busy (
        .clk(clk), .rst_n(rst_n), .start(we_q), .busy(busy)
    );

    assign new_byte  = {shreg[DATA_W-2:0], mosi_s};
    assign status    = {4'b0000, PROTECT, wel_q, busy};
    assign commit_ok = (ph == PH_DATA) && (cmd == CMD_WRITE) && (bcnt == WR_BITS)
                       && wel_q && !wr_blocked;

    // instruction sequencing, write commit on deselect, serial output shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph <= PH_OPC;  cmd <= CMD_READ;  shreg <= '0;  bcnt <= '0;
            a8 <= 1'b0;  addr_q <= '0;  wel_q <= 1'b0;  wren_pend <= 1'b0;
            out_sh <= '0;  out_bits <= '0;  load_req <= 1'b0;  we_q <= 1'b0;
            wdata_q <= '0;  miso_q <= 1'b0;  oe_q <= 1'b0;
        end else begin
            we_q <= 1'b0;
            if (sel_end) begin
                ph <= PH_OPC;  bcnt <= '0;  oe_q <= 1'b0;  load_req <= 1'b0;
                wren_pend <= 1'b0;
                if (wren_pend) wel_q <= 1'b1;
                if (commit_ok) begin
                    we_q    <= 1'b1;
                    wdata_q <= shreg;
                    wel_q   <= 1'b0;
                end
            end else if (sel) begin
                if (sck_rise) begin
                    shreg     <= new_byte;
                    wren_pend <= 1'b0;
                    if (bcnt != CNT_SAT) bcnt <= bcnt + 1'b1;
                    case (ph)
                        PH_OPC: if (bcnt == OPC_LAST) begin
                            a8       <= new_byte[3];
                            out_bits <= '0;
                            if (new_byte == OPC_RDSR) begin
                                cmd <= CMD_RDSR;  ph <= PH_OUT;  load_req <= 1'b1;
                            end else if (busy) begin
                                ph <= PH_SKIP;
                            end else if ((new_byte & OPC_MASK) == OPC_READ) begin
                                cmd <= CMD_READ;  ph <= PH_ADDR;
                            end else if ((new_byte & OPC_MASK) == OPC_WRITE) begin
                                cmd <= CMD_WRITE; ph <= PH_ADDR;
                            end else if (new_byte == OPC_WREN) begin
                                wren_pend <= 1'b1; ph <= PH_SKIP;
                            end else begin
                                ph <= PH_SKIP;
                            end
                        end
                        PH_ADDR: if (bcnt == ADR_LAST) begin
                            addr_q <= {a8, new_byte};
                            if (cmd == CMD_WRITE) ph <= PH_DATA;
                            else begin ph <= PH_OUT; load_req <= 1'b1; end
                        end
                        default: ;
                    endcase
                end else if (sck_fall && ph == PH_OUT && !load_req) begin
                    miso_q   <= out_sh[DATA_W-1];
                    oe_q     <= 1'b1;
                    out_bits <= out_bits + 1'b1;
                    if (out_bits == 3'd7) begin
                        load_req <= 1'b1;
                        if (cmd == CMD_READ) addr_q <= addr_q + 1'b1;
                    end else begin
                        out_sh <= {out_sh[DATA_W-2:0], 1'b0};
                    end
                end else if (load_req) begin
                    out_sh   <= (cmd == CMD_RDSR) ? status : rdata;
                    load_req <= 1'b0;
                end
            end
        end
    end

    assign miso    = miso_q;
    assign miso_oe = oe_q;

    AST_OE_QUIET_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !miso_oe); // R7
    AST_OE_QUIET_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_OPC) |-> !miso_oe); // R7
    AST_WRITE_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        we_q |-> $past(wel_q)); // R2
    AST_LATCH_DROPS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        we_q |-> !wel_q); // R9
    AST_NO_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        we_q |-> !busy); // R8
endmodule

// File: tb/test_spi_eeprom_slave.sv
// Scoreboard bench: driver tasks queue expected reply bytes, a monitor
// compares them with the bytes the serial master actually receives.
module test_spi_eeprom_slave;
    localparam int HALF = 8;
    localparam int BUSY = 1200;

    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic miso, miso_oe;
    int vectors = 0, fails = 0;
    logic [7:0] exp_v[$], got_v[$];
    string      exp_tag[$];
    logic [7:0] d8;
    logic       doe;

    always #4 clk = ~clk;   // 125 MHz

    spi_eeprom_slave #(.BUSY_CYCLES(BUSY)) i_spi_eeprom_slave (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .miso(miso), .miso_oe(miso_oe)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic expect_byte(input logic [7:0] v, input string tag);
        exp_v.push_back(v);
        exp_tag.push_back(tag);
    endtask

    // monitor: pop and compare each received byte against the scoreboard
    initial forever begin
        @(negedge clk);
        while (got_v.size() > 0 && exp_v.size() > 0)
            check(exp_tag.pop_front(), got_v.pop_front(), exp_v.pop_front());
    end

    task automatic sel();
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic desel();
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (4 * HALF) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] tx, input int nbits,
                        output logic [7:0] rx, output logic oe_any);
        rx = '0;  oe_any = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            mosi = tx[7-i];
            repeat (HALF) @(negedge clk);
            rx = {rx[6:0], miso};
            oe_any |= miso_oe;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic read_op(input logic [7:0] op, input logic [7:0] a, input int n,
                           input bit exp_oe, input string tag);
        logic [7:0] rx;  logic oe;
        sel();
        xfer(op, 8, rx, oe);  check({tag, " oe in opcode"}, {7'd0, oe}, 8'd0);
        xfer(a, 8, rx, oe);   check({tag, " oe in address"}, {7'd0, oe}, 8'd0);
        for (int k = 0; k < n; k++) begin
            xfer(8'h00, 8, rx, oe);
            check({tag, " oe in data"}, {7'd0, oe}, {7'd0, exp_oe});
            if (exp_oe) got_v.push_back(rx);
        end
        desel();
    endtask

    task automatic rdsr(input int n);
        logic [7:0] rx;  logic oe;
        sel();
        xfer(8'h05, 8, rx, oe);  check("R7 oe in status opcode", {7'd0, oe}, 8'd0);
        for (int k = 0; k < n; k++) begin
            xfer(8'h00, 8, rx, oe);
            got_v.push_back(rx);
        end
        desel();
    endtask

    task automatic write_op(input logic [7:0] op, input logic [7:0] a,
                            input logic [7:0] d, input int nbits);
        logic [7:0] rx;  logic oe;
        sel();
        xfer(op, 8, rx, oe);
        xfer(a, 8, rx, oe);
        xfer(d, (nbits >= 24) ? 8 : nbits - 16, rx, oe);
        if (nbits > 24) xfer(8'h00, nbits - 24, rx, oe);
        desel();
    endtask

    task automatic wren();
        sel();  xfer(8'h06, 8, d8, doe);  desel();
    endtask

    task automatic settle();
        repeat (BUSY + 300) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 oe after reset", {7'd0, miso_oe}, 8'd0);
        expect_byte(8'h04, "R1 status after reset");  rdsr(1);
        expect_byte(8'hFF, "R1 erased 000");  expect_byte(8'hFF, "R1 erased 001");
        read_op(8'h03, 8'h00, 2, 1'b1, "R1");

        write_op(8'h02, 8'h10, 8'h5A, 24);                       // no latch
        expect_byte(8'hFF, "R2 write without latch");  read_op(8'h03, 8'h10, 1, 1'b1, "R2");
        expect_byte(8'h04, "R2 latch still clear");    rdsr(1);
        wren();
        expect_byte(8'h06, "R2 latch set");  expect_byte(8'h06, "R7 status repeats");  rdsr(2);

        write_op(8'h02, 8'h10, 8'h5A, 24);
        read_op(8'h03, 8'h10, 1, 1'b0, "R8 read ignored while busy");
        expect_byte(8'h05, "R8 R9 busy set latch cleared");  rdsr(1);
        settle();
        expect_byte(8'h04, "R8 busy cleared");  rdsr(1);
        expect_byte(8'h5A, "R3 stored byte");   read_op(8'h03, 8'h10, 1, 1'b1, "R3");

        wren();  write_op(8'h0A, 8'h23, 8'hC3, 24);  settle();
        expect_byte(8'hC3, "R3 address bit 8 in opcode");  read_op(8'h0B, 8'h23, 1, 1'b1, "R3");
        expect_byte(8'hFF, "R6 low page untouched");       read_op(8'h03, 8'h23, 1, 1'b1, "R6");

        wren();  write_op(8'h02, 8'h00, 8'h11, 24);  settle();
        expect_byte(8'hFF, "R6 seq 00F");  expect_byte(8'h5A, "R6 seq 010");
        expect_byte(8'hFF, "R6 seq 011");  read_op(8'h03, 8'h0F, 3, 1'b1, "R6");
        expect_byte(8'hFF, "R6 wrap 1FF");  expect_byte(8'h11, "R6 wrap 000");
        read_op(8'h0B, 8'hFF, 2, 1'b1, "R6");

        wren();
        write_op(8'h02, 8'h30, 8'h99, 23);
        expect_byte(8'h06, "R4 23 bits dropped latch kept");  rdsr(1);
        write_op(8'h02, 8'h30, 8'h99, 25);
        expect_byte(8'h06, "R4 25 bits dropped latch kept");  rdsr(1);
        expect_byte(8'hFF, "R4 array unchanged");  read_op(8'h03, 8'h30, 1, 1'b1, "R4");

        write_op(8'h0A, 8'hA5, 8'h66, 24);
        expect_byte(8'h06, "R5 protected write dropped");  rdsr(1);
        expect_byte(8'hFF, "R5 protected byte unchanged");  read_op(8'h0B, 8'hA5, 1, 1'b1, "R5");
        write_op(8'h0A, 8'h7F, 8'h42, 24);  settle();
        expect_byte(8'h42, "R5 boundary 17F writable");  read_op(8'h0B, 8'h7F, 1, 1'b1, "R5");

        sel();
        xfer(8'h06, 8, d8, doe);  xfer(8'h02, 8, d8, doe);
        xfer(8'h60, 8, d8, doe);  xfer(8'hAA, 8, d8, doe);
        desel();
        expect_byte(8'h04, "R2 same-select write leaves latch clear");  rdsr(1);
        expect_byte(8'hFF, "R2 same-select write not stored");  read_op(8'h03, 8'h60, 1, 1'b1, "R2");

        read_op(8'hFF, 8'h10, 2, 1'b0, "R11 unknown opcode");
        expect_byte(8'h04, "R11 status unchanged");  rdsr(1);

        sel();
        xfer(8'h03, 8, d8, doe);  xfer(8'h10, 8, d8, doe);  xfer(8'h00, 4, d8, doe);
        desel();
        sel();  xfer(8'h06, 4, d8, doe);  desel();
        expect_byte(8'h04, "R10 partial enable sets nothing");  rdsr(1);
        expect_byte(8'h5A, "R10 fresh read after abort");  read_op(8'h03, 8'h10, 1, 1'b1, "R10");

        repeat (20) @(negedge clk);
        if (exp_v.size() != 0) begin
            vectors++;  fails++;
            $display("FAIL scoreboard: got %0d bytes expected %0d more", 0, exp_v.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    // watchdog: a hung run counts as a failed check
    initial begin
        repeat (190000) @(posedge clk);
        vectors++;  fails++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule